// File: doc/BRIEF.md
# Floppy Disk Bit-Stream Serializer/Deserializer

This block is the data path of a floppy disk controller. It moves bytes between an 8-bit host bus and the single serial data line that runs to or from the drive head. One shift register and one holding buffer carry traffic in both directions. A mode input chooses the direction, so the block never reads and writes at once. Bit-cell timing comes from the system clock divided by a parameter. A slow-select input makes every cell twice as long.

In write mode, the host places a byte in the buffer. At the end of each byte, the buffer moves into the shift register, and the register drives the write line most significant bit first, one bit per cell. A flag tells the host that the buffer can take the next byte. A sticky flag records an underrun, which is a reload that found no new byte. In read mode, the incoming line is sampled in the middle of each cell. The cell timer is realigned on every level change of the line, and zeros that come before a byte's first one are skipped. Each finished byte lands in the buffer and raises a data-valid flag, which the host clears by reading the byte. A small address field selects the buffer, a status byte, or a byte that carries the external sense input in its top bit.

Top module: `dsk_serdes`

## Requirements
- R1: After reset, the buffer and shift register are zero, all flags are clear, `wr_data` is low, and address 0 and address 1 both read as zero while in read mode.
- R2: A bit cell lasts CELL_CLKS clocks (16 by default) when `slow` is 0 and twice that when `slow` is 1. In write mode, successive byte reloads are exactly 8 cells apart.
- R3: In write mode, `wr_data` carries the shift register's top bit, so a byte leaves most significant bit first, and each bit is held for one full cell.
- R4: In write mode, a host write to address 0 loads the buffer and clears both the buffer-empty flag and the underrun flag.
- R5: In write mode, after the eighth bit of a byte, the shift register reloads from the buffer and the buffer-empty flag is set.
- R6: A reload that finds the buffer empty sets the underrun flag and sends the stale buffer contents again. The flag stays set until the next host write to address 0.
- R7: In read mode, `rd_data` is sampled half a cell after the most recent level change and then once per cell. Zero samples taken before a byte's first one are skipped. Eight samples form a byte, first sample in the top bit.
- R8: When the eighth bit of a byte arrives in read mode, the byte is copied into the buffer and the data-valid flag is set. A host read of address 0 clears the flag.
- R9: In read mode, host writes leave the buffer unchanged and `wr_data` stays low.
- R10: The read data at each address is as follows. Address 1 returns {flag, underrun, 5'b0, slow}, where flag is buffer-empty in write mode and data-valid in read mode. Address 2 returns {sense_in, 7'b0}. Address 3 returns zero.
- R11: A change of `mode_wr` restarts the cell timer and bit counter and clears the shift register and all flags, but keeps the buffer contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_wr | input | 1 | 1 = write to disk, 0 = read from disk |
| slow | input | 1 | 1 doubles the bit-cell length |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | 2 | 0 buffer, 1 status, 2 sense, 3 none |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Byte returned to the host (combinational from address) |
| rd_data | input | 1 | Serial data from the drive |
| wr_data | output | 1 | Serial data to the drive |
| sense_in | input | 1 | External sense line, visible on address 2 bit 7 |

## Verification
The bench keeps the default parameters: an 8-bit data width and a 16-clock normal cell. It toggles `slow` between runs, so the 32-clock cell is exercised as well as the 16-clock one. With these values, a full byte in either direction takes at most 256 clocks. The bench can therefore check reload spacing to the exact cycle and check each bit at its cell midpoint, and it can play an unbroken run of bytes into an underrun while staying well inside the time limit. A short cell also lets long runs of equal bits, such as 0x80 and 0xFF, test the free-running cell timer between realignments.

// File: rtl/dsk_serdes_pkg.sv
`timescale 1ns/1ps
// Package: shared host address decode for the disk serializer.
// Assumes a two-bit host address field.
package dsk_serdes_pkg;
    typedef enum logic [1:0] {
        SEL_BUF   = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_SENSE = 2'd2,
        SEL_NONE  = 2'd3
    } host_sel_e;
endpackage

// File: rtl/dsk_cell_timer.sv
`timescale 1ns/1ps
// Module: bit-cell timer. It counts system clocks within a cell and flags the
// last clock and the middle clock of each cell. The cell is CELL_CLKS long,
// or twice that when slow is set. Assumes CELL_CLKS is even and at least 4.
module dsk_cell_timer #(
    parameter int CELL_CLKS = 16,
    localparam int TW = $clog2(2 * CELL_CLKS) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow,
    input  logic restart,
    input  logic resync,
    output logic tick_end,
    output logic tick_mid
);
    logic [TW-1:0] cnt;
    logic [TW-1:0] len_m1;
    logic [TW-1:0] half;

    // Purpose: pick the cell length and midpoint for the current speed.
    always_comb begin
        len_m1 = slow ? TW'(2 * CELL_CLKS - 1) : TW'(CELL_CLKS - 1);
        half   = slow ? TW'(CELL_CLKS) : TW'(CELL_CLKS / 2);
    end

    assign tick_end = (cnt >= len_m1);
    assign tick_mid = (cnt == half);

    // Purpose: advance the counter; restart zeroes it, a transition realigns it.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (restart)  cnt <= '0;
        else if (resync)   cnt <= TW'(1);
        else if (tick_end) cnt <= '0;
        else               cnt <= cnt + TW'(1);
    end

    // R2: the counter never runs past the longest cell
    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TW'(2 * CELL_CLKS - 1));
    // R2: the cell ends and the counter wraps to zero
    a_r2_cell_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_end && !restart && !resync) |=> (cnt == '0));
endmodule

// File: rtl/dsk_datapath.sv
`timescale 1ns/1ps
// Module: shared shift register and buffer with bit counter and flags.
// Write mode: buffer -> shift register -> serial out, MSB first.
// Read mode: serial in -> shift register -> buffer, leading zeros skipped.
// Assumes the strobes from the timer and the host port are single-cycle.
module dsk_datapath #(
    parameter int DATA_W = 8,
    localparam int CW = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              restart,
    input  logic              tick_end,
    input  logic              tick_mid,
    input  logic              rd_bit,
    input  logic              rd_edge,
    input  logic              host_wr_buf,
    input  logic              host_rd_buf,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              ser_msb,
    output logic [DATA_W-1:0] buf_q,
    output logic              dvalid,
    output logic              empty,
    output logic              underrun
);
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [CW-1:0]     bitcnt;
    logic              buf_full;
    logic              wr_load, wr_shift, rd_samp, rd_take, rd_done, host_load;
    logic [DATA_W-1:0] rd_next;

    // Purpose: decode the per-cycle actions from mode, timer and host strobes.
    always_comb begin
        wr_load   = mode_wr && !restart && tick_end && (bitcnt == LAST);
        wr_shift  = mode_wr && !restart && tick_end && (bitcnt != LAST);
        rd_samp   = !mode_wr && !restart && tick_mid && !rd_edge;
        rd_take   = rd_samp && ((bitcnt != '0) || rd_bit);
        rd_done   = rd_take && (bitcnt == LAST);
        host_load = mode_wr && host_wr_buf;
        rd_next   = {shreg[DATA_W-2:0], rd_bit};
    end

    // Purpose: shift register load, shift left, or shift in a sample.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (restart)  shreg <= '0;
        else if (wr_load)  shreg <= buf_q;
        else if (wr_shift) shreg <= {shreg[DATA_W-2:0], 1'b0};
        else if (rd_take)  shreg <= rd_next;
    end

    // Purpose: count bits within a byte; write mode starts at the reload point.
    always_ff @(posedge clk) begin
        if (!rst_n)                   bitcnt <= '0;
        else if (restart)             bitcnt <= mode_wr ? LAST : '0;
        else if (wr_load || rd_done)  bitcnt <= '0;
        else if (wr_shift || rd_take) bitcnt <= bitcnt + CW'(1);
    end

    // Purpose: buffer takes host bytes in write mode, finished bytes in read mode.
    always_ff @(posedge clk) begin
        if (!rst_n)         buf_q <= '0;
        else if (host_load) buf_q <= host_wdata;
        else if (rd_done)   buf_q <= rd_next;
    end

    // Purpose: track whether the buffer holds a byte not yet sent.
    always_ff @(posedge clk) begin
        if (!rst_n)         buf_full <= 1'b0;
        else if (restart)   buf_full <= host_load;
        else if (host_load) buf_full <= 1'b1;
        else if (wr_load)   buf_full <= 1'b0;
    end

    // Purpose: sticky underrun, set by a reload from an empty buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)                      underrun <= 1'b0;
        else if (restart)                underrun <= 1'b0;
        else if (wr_load && !buf_full)   underrun <= 1'b1;
        else if (host_load)              underrun <= 1'b0;
    end

    // Purpose: data-valid flag, set by a finished byte, cleared by a host read.
    always_ff @(posedge clk) begin
        if (!rst_n)           dvalid <= 1'b0;
        else if (restart)     dvalid <= 1'b0;
        else if (rd_done)     dvalid <= 1'b1;
        else if (host_rd_buf) dvalid <= 1'b0;
    end

    assign ser_msb = shreg[DATA_W-1];
    assign empty   = !buf_full;

    // R3: between reloads the register moves one place toward the output
    a_r3_shift_one: assert property (@(posedge clk) disable iff (!rst_n)
        wr_shift |=> (shreg == {$past(shreg[DATA_W-2:0]), 1'b0}));
    // R5: a reload copies the buffer and leaves it empty unless refilled
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load && !host_load) |=> (shreg == $past(buf_q) && empty));
    // R6: a reload from an empty buffer flags an underrun
    a_r6_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load && !buf_full) |=> underrun);
    // R8: a finished byte lands in the buffer with data-valid set
    a_r8_byte_done: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (dvalid && buf_q == $past(rd_next)));
    // R9: in read mode the buffer changes only when a byte completes
    a_r9_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_wr && !rd_done && !host_load) |=> $stable(buf_q));
    // R11: a mode change clears the shift register
    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (shreg == '0 && !dvalid && !underrun));
endmodule

// File: rtl/dsk_host_port.sv
`timescale 1ns/1ps
// Module: host-side decode. It forms the buffer read and write strobes and
// returns the byte selected by the address. Read data is combinational.
// Assumes DATA_W of at least 3 so the status layout fits.
module dsk_host_port
    import dsk_serdes_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              mode_wr,
    input  logic              slow,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic              sense_in,
    input  logic [DATA_W-1:0] buf_q,
    input  logic              dvalid,
    input  logic              empty,
    input  logic              underrun,
    output logic              host_wr_buf,
    output logic              host_rd_buf,
    output logic [DATA_W-1:0] host_rdata
);
    host_sel_e sel;
    logic      flag;

    // Purpose: decode strobes and pick the returned byte.
    always_comb begin
        sel         = host_sel_e'(host_addr);
        host_wr_buf = host_sel && host_we && (sel == SEL_BUF);
        host_rd_buf = host_sel && !host_we && (sel == SEL_BUF);
        flag        = mode_wr ? empty : dvalid;
        case (sel)
            SEL_BUF:   host_rdata = buf_q;
            SEL_STAT:  host_rdata = {flag, underrun, {(DATA_W-3){1'b0}}, slow};
            SEL_SENSE: host_rdata = {sense_in, {(DATA_W-1){1'b0}}};
            default:   host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dsk_serdes.sv
`timescale 1ns/1ps
// Module: floppy disk data serializer/deserializer top. It synchronises the
// read line, detects mode changes, and joins the cell timer, the data path and
// the host port. Assumes rd_data is asynchronous; mode_wr and slow come from
// the clk domain.
module dsk_serdes #(
    parameter int DATA_W    = 8,
    parameter int CELL_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              slow,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              rd_data,
    output logic              wr_data,
    input  logic              sense_in
);
    logic rd_s, rd_q, mode_q;
    logic restart, rd_edge;
    logic tick_end, tick_mid;
    logic host_wr_buf, host_rd_buf;
    logic ser_msb, dvalid, empty, underrun;
    logic [DATA_W-1:0] buf_q;

    // Purpose: register the read line twice and remember the last mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_s   <= 1'b0;
            rd_q   <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            rd_s   <= rd_data;
            rd_q   <= rd_s;
            mode_q <= mode_wr;
        end
    end

    assign restart = mode_q ^ mode_wr;
    assign rd_edge = rd_s ^ rd_q;
    assign wr_data = mode_wr & ser_msb;

    dsk_cell_timer #(.CELL_CLKS(CELL_CLKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow     (slow),
        .restart  (restart),
        .resync   (rd_edge & ~mode_wr),
        .tick_end (tick_end),
        .tick_mid (tick_mid)
    );

    dsk_datapath #(.DATA_W(DATA_W)) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr     (mode_wr),
        .restart     (restart),
        .tick_end    (tick_end),
        .tick_mid    (tick_mid),
        .rd_bit      (rd_s),
        .rd_edge     (rd_edge),
        .host_wr_buf (host_wr_buf),
        .host_rd_buf (host_rd_buf),
        .host_wdata  (host_wdata),
        .ser_msb     (ser_msb),
        .buf_q       (buf_q),
        .dvalid      (dvalid),
        .empty       (empty),
        .underrun    (underrun)
    );

    dsk_host_port #(.DATA_W(DATA_W)) u_host (
        .mode_wr     (mode_wr),
        .slow        (slow),
        .host_sel    (host_sel),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .sense_in    (sense_in),
        .buf_q       (buf_q),
        .dvalid      (dvalid),
        .empty       (empty),
        .underrun    (underrun),
        .host_wr_buf (host_wr_buf),
        .host_rd_buf (host_rd_buf),
        .host_rdata  (host_rdata)
    );

    // R1: the write line is low in the cycle after reset
    a_r1_reset_line: assert property (@(posedge clk)
        !rst_n |=> !wr_data);
endmodule

// File: tb/dsk_serdes_bench.sv
`timescale 1ns/1ps
module dsk_serdes_bench;
    logic       clk = 1'b0;
    logic       rst_n, mode_wr, slow, host_sel, host_we, rd_data, sense_in;
    logic [1:0] host_addr;
    logic [7:0] host_wdata, host_rdata;
    logic       wr_data;
    int         n_chk = 0, n_fail = 0, cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dsk_serdes u_dsk_serdes (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .slow(slow),
        .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rd_data(rd_data), .wr_data(wr_data), .sense_in(sense_in));

    function automatic logic [7:0] exp_status(input logic f, input logic u, input logic s);
        return {f, u, 5'b0, s};
    endfunction

    function automatic int cell_len(input logic s);
        return s ? 32 : 16;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        host_sel = 1'b0; host_addr = a; #1; d = host_rdata;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
        host_sel = 1'b1; host_we = 1'b0; host_addr = a; #1; d = host_rdata;
        @(negedge clk); host_sel = 1'b0;
    endtask

    task automatic host_wr(input logic [7:0] d);
        host_sel = 1'b1; host_we = 1'b1; host_addr = 2'd0; host_wdata = d;
        @(negedge clk); host_sel = 1'b0; host_we = 1'b0;
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Serial byte into the read line, MSB first, then a check of buffer and flag.
    task automatic rx_byte(input logic [7:0] b);
        logic [7:0] d;
        int len;
        len = cell_len(slow);
        for (int i = 7; i >= 0; i--) begin
            rd_data = b[i];
            repeat (len / 2) @(negedge clk);
            chk(wr_data == 1'b0, "R9 write line low in read", wr_data, 0);
            repeat (len - len / 2) @(negedge clk);
        end
        rd_data = 1'b0;
        peek(2'd1, d);
        chk(d == exp_status(1'b1, 1'b0, slow), "R8 data-valid after byte", d, exp_status(1'b1, 1'b0, slow));
        host_rd(2'd0, d);
        chk(d == b, "R7 assembled byte", d, b);
        peek(2'd1, d);
        chk(d == exp_status(1'b0, 1'b0, slow), "R8 read clears data-valid", d, exp_status(1'b0, 1'b0, slow));
        repeat (len * (1 + ($urandom % 3))) @(negedge clk);
    endtask

    // Wait for a reload; returns the cycle index of the first sample after it.
    task automatic wait_reload(output int n0);
        logic [7:0] d;
        n0 = -1;
        for (int k = 0; k < 400; k++) begin
            peek(2'd1, d);
            if (d[7]) begin n0 = cyc; break; end
            @(negedge clk);
        end
        chk(n0 >= 0, "R5 reload seen", n0, 0);
    endtask

    task automatic check_bits(input int n0, input logic [7:0] b, input string req);
        int len, half;
        len = cell_len(slow); half = len / 2;
        for (int i = 7; i >= 0; i--) begin
            wait_to(n0 + half + (7 - i) * len);
            chk(wr_data == b[i], req, wr_data, b[i]);
        end
    endtask

    // A run of bytes ending in an underrun.
    task automatic tx_run(input int nbytes);
        logic [7:0] bytes [0:5];
        logic [7:0] d;
        int n0, len;
        len = cell_len(slow);
        bytes[0] = 8'hA5; bytes[1] = 8'h01;
        for (int k = 2; k < 6; k++) bytes[k] = 8'($urandom);
        host_wr(bytes[0]);
        peek(2'd1, d);
        chk(d == exp_status(1'b0, 1'b0, slow), "R4 write clears empty and underrun", d, exp_status(1'b0, 1'b0, slow));
        wait_reload(n0);
        for (int k = 0; k < nbytes; k++) begin
            if (k + 1 < nbytes) host_wr(bytes[k + 1]);
            check_bits(n0, bytes[k], "R3 serial bit MSB first");
            wait_to(n0 + 8 * len - 1);
            peek(2'd1, d);
            if (k + 1 < nbytes)
                chk(d[7] == 1'b0, "R2 no reload before 8 cells", d[7], 0);
            wait_to(n0 + 8 * len);
            peek(2'd1, d);
            chk(d[7] == 1'b1, "R2 reload exactly 8 cells later", d[7], 1);
            chk(d[6] == (k + 1 >= nbytes), "R6 underrun flag", d[6], (k + 1 >= nbytes));
            n0 = n0 + 8 * len;
        end
        check_bits(n0, bytes[nbytes - 1], "R6 stale byte resent");
        host_wr(8'h3C);
        peek(2'd1, d);
        chk(d[6] == 1'b0, "R6 host write clears underrun", d[6], 0);
    endtask

    initial begin
        logic [7:0] d;
        logic [7:0] last_rx;
        void'($urandom(32'd2024));
        rst_n = 1'b0; mode_wr = 1'b0; slow = 1'b0; host_sel = 1'b0; host_we = 1'b0;
        host_addr = 2'd0; host_wdata = 8'h00; rd_data = 1'b0; sense_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        peek(2'd0, d); chk(d == 8'h00, "R1 buffer zero", d, 0);
        peek(2'd1, d); chk(d == exp_status(1'b0, 1'b0, 1'b0), "R1 status zero", d, 0);
        chk(wr_data == 1'b0, "R1 write line low", wr_data, 0);

        sense_in = 1'b1; peek(2'd2, d); chk(d == 8'h80, "R10 sense high", d, 8'h80);
        sense_in = 1'b0; peek(2'd2, d); chk(d == 8'h00, "R10 sense low", d, 0);
        peek(2'd3, d); chk(d == 8'h00, "R10 unused address", d, 0);
        slow = 1'b1; peek(2'd1, d); chk(d == exp_status(1'b0, 1'b0, 1'b1), "R10 slow bit", d, 8'h01);
        slow = 1'b0;

        host_wr(8'h5A);
        peek(2'd0, d); chk(d == 8'h00, "R9 host write ignored in read", d, 0);

        repeat (10 * 16) @(negedge clk);
        peek(2'd1, d); chk(d[7] == 1'b0, "R7 leading zeros skipped", d[7], 0);

        rx_byte(8'h80); rx_byte(8'hFF); rx_byte(8'hAA); rx_byte(8'hD5);
        for (int k = 0; k < 10; k++) begin
            slow = 1'($urandom);
            last_rx = 8'($urandom) | 8'h80;
            rx_byte(last_rx);
        end

        slow = 1'b0; mode_wr = 1'b1;
        repeat (2) @(negedge clk);
        peek(2'd1, d); chk(d == exp_status(1'b1, 1'b0, 1'b0), "R11 flags after mode change", d, 8'h80);
        peek(2'd0, d); chk(d == last_rx, "R11 buffer kept", d, last_rx);
        tx_run(4);

        mode_wr = 1'b0; repeat (2) @(negedge clk);
        peek(2'd1, d); chk(d == exp_status(1'b0, 1'b0, 1'b0), "R11 flags cleared on read", d, 0);
        slow = 1'b1; mode_wr = 1'b1; repeat (2) @(negedge clk);
        tx_run(3);

        mode_wr = 1'b0; slow = 1'b0; repeat (2) @(negedge clk);
        rx_byte(8'hC3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual %0d expected below 200000 cycles", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule